// File: doc/BRIEF.md
# Buffered-Compare PWM Timer

This block is an up-counting timer with a programmable period limit and one output-compare channel. On each cycle in which the count-enable strobe is high, the counter advances. When the counter arrives at the compare value by counting, a compare event is raised. That event sets a sticky interrupt flag and, in PWM operation, moves the waveform output. A small register port gives software read and write access to the counter, the compare value, the period limit and a control word. The control word holds the PWM enable, the two-bit output mode and the flag.

In PWM operation the counter runs from zero up to the period limit and then starts again at zero. Writes to the compare value land in a holding register. They reach the active compare register only on the step that takes the counter from the limit back to zero, so each period uses one consistent threshold and no short pulses appear. Outside PWM operation the counter simply wraps at its full range, and compare writes take effect at once.

Top module: `pwm_cmp_timer`

## Requirements
- R1: After reset the counter reads 0x00, the compare value reads 0x00, the period limit reads 0xFF, the control word reads 0x00, and the flag, `pwm_out` and `pwm_oe` are all low.
- R2: Each clock edge with `cnt_en` high adds one to the counter. With PWM off, the counter steps from 0xFF to 0x00. A counter write (address 0) in the same cycle takes priority over counting.
- R3: With PWM on (control bit 0), the counter steps from the period limit (address 2) to 0x00.
- R4: When the counter arrives at the active compare value through a counting step at edge k, the flag is still low before edge k+1 and high after it.
- R5: A counter write that makes the counter equal to the compare value does not set the flag.
- R6: Writing the control word (address 3) with the top bit (bit 7) at one clears the flag. A compare event at the same edge keeps the flag set.
- R7: With PWM off, a compare write (address 1) is active and readable right away.
- R8: With PWM on, a compare write is held back. The compare value read back stays the old active value until the edge where the counter steps from the period limit to 0x00; that edge makes the held value active.
- R9: Unless PWM is on and the output mode (control bits 2:1) is 10 or 11, `pwm_oe` and `pwm_out` are both low.
- R10: Mode 10: the edge after the counter arrives at 0x00 by counting drives the output high. The edge after it arrives at the compare value drives it low. If both happen together, the compare rule wins.
- R11: Mode 11 mirrors mode 10: compare drives the output high and arrival at 0x00 drives it low, and again the compare rule wins.
- R12: A compare value of 0x00 gives a steady low output in mode 10, and a compare value above the period limit gives a steady high output, with no pulses in either case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cnt_en | input | 1 | Count-enable strobe, one step per high cycle |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select: 0 counter, 1 compare, 2 period limit, 3 control |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register (combinational) |
| pwm_out | output | 1 | PWM waveform output |
| pwm_oe | output | 1 | High while the waveform drives the pin |
| cmp_irq | output | 1 | Compare interrupt flag |

## Verification
The bench builds the block with its defaults: an 8-bit datapath and a period limit that resets to 0xFF. The full-range wrap is reached by loading the counter near its top. The bench then programs a period limit of 4, which gives five-cycle periods. With periods that short, many limit-to-zero commits happen in a short run. This brings several cases within reach in a few dozen cycles: a buffered compare write landing mid-period, a compare of zero where both output rules meet, a compare above the limit that never matches, and switching between the two waveform polarities.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  typedef enum logic [1:0] {
    SEL_COUNT = 2'd0,
    SEL_CMP   = 2'd1,
    SEL_TOP   = 2'd2,
    SEL_CTRL  = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    OUT_OFF_A        = 2'b00,
    OUT_OFF_B        = 2'b01,
    OUT_CLR_ON_MATCH = 2'b10,
    OUT_SET_ON_MATCH = 2'b11
  } out_mode_e;

  localparam int CTRL_PWM_BIT  = 0;
  localparam int CTRL_MODE_LSB = 1;
  localparam int CTRL_MODE_W   = 2;
endpackage

// File: rtl/pwm_tmr_rst_sync.sv
module pwm_tmr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/pwm_tmr_counter.sv
module pwm_tmr_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_en,
  input  logic         pwm_en,
  input  logic [W-1:0] top_val,
  input  logic         ld_en,
  input  logic [W-1:0] ld_val,
  input  logic [W-1:0] cmp_val,
  output logic [W-1:0] cnt_q,
  output logic         commit,
  output logic         hit_cmp,
  output logic         hit_bottom
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [W-1:0] ZERO = '0;
  localparam logic [W-1:0] ONE  = W'(1);

  logic [W-1:0] cnt_d;
  logic         arrived_q;
  logic         arrived_d;
  logic         at_top;
  logic         step;

  assign at_top = (cnt_q == top_val);
  assign step   = cnt_en & ~ld_en;
  // Period restart in PWM operation is also the buffer commit point
  assign commit = step & pwm_en & at_top;

  always_comb begin
    cnt_d     = cnt_q;
    arrived_d = 1'b0;
    if (ld_en) begin
      cnt_d = ld_val;
    end else if (cnt_en) begin
      arrived_d = 1'b1;
      if (pwm_en && at_top) begin
        cnt_d = ZERO;
      end else begin
        cnt_d = cnt_q + ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= ZERO;
      arrived_q <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      arrived_q <= arrived_d;
    end
  end

  // Events only count when the present value was reached by a counting step
  assign hit_cmp    = arrived_q & (cnt_q == cmp_val);
  assign hit_bottom = arrived_q & (cnt_q == ZERO);
endmodule

// File: rtl/pwm_tmr_regs.sv
module pwm_tmr_regs
  import pwm_tmr_pkg::*;
#(
  parameter int           W       = 8,
  parameter logic [W-1:0] TOP_RST = '1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_we,
  input  logic [1:0]             bus_addr,
  input  logic [W-1:0]           bus_wdata,
  output logic [W-1:0]           bus_rdata,
  input  logic [W-1:0]           cnt_q,
  input  logic                   commit,
  input  logic                   hit_cmp,
  output logic                   ld_en,
  output logic [W-1:0]           ld_val,
  output logic [W-1:0]           top_q,
  output logic [W-1:0]           cmp_act_q,
  output logic                   pwm_en_q,
  output logic [CTRL_MODE_W-1:0] mode_q,
  output logic                   flag_q
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int FLAG_BIT = W - 1;

  reg_sel_e               sel;
  logic                   wr_cmp;
  logic                   wr_top;
  logic                   wr_ctrl;
  logic [W-1:0]           cmp_hold_q;
  logic [W-1:0]           cmp_hold_d;
  logic [W-1:0]           cmp_act_d;
  logic [W-1:0]           top_d;
  logic                   pwm_en_d;
  logic [CTRL_MODE_W-1:0] mode_d;
  logic                   flag_d;
  logic                   flag_clr;
  logic [W-1:0]           ctrl_view;

  assign sel     = reg_sel_e'(bus_addr);
  assign ld_en   = bus_we & (sel == SEL_COUNT);
  assign ld_val  = bus_wdata;
  assign wr_cmp  = bus_we & (sel == SEL_CMP);
  assign wr_top  = bus_we & (sel == SEL_TOP);
  assign wr_ctrl = bus_we & (sel == SEL_CTRL);
  assign flag_clr = wr_ctrl & bus_wdata[FLAG_BIT];

  always_comb begin
    cmp_hold_d = cmp_hold_q;
    cmp_act_d  = cmp_act_q;
    if (wr_cmp) begin
      cmp_hold_d = bus_wdata;
      if (!pwm_en_q) begin
        cmp_act_d = bus_wdata;
      end
    end
    if (commit) begin
      cmp_act_d = cmp_hold_q;
    end
  end

  always_comb begin
    top_d    = wr_top  ? bus_wdata : top_q;
    pwm_en_d = wr_ctrl ? bus_wdata[CTRL_PWM_BIT] : pwm_en_q;
    mode_d   = wr_ctrl ? bus_wdata[CTRL_MODE_LSB +: CTRL_MODE_W] : mode_q;
    // Hardware set wins over a software clear in the same cycle
    flag_d   = hit_cmp | (flag_q & ~flag_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_hold_q <= '0;
      cmp_act_q  <= '0;
      top_q      <= TOP_RST;
      pwm_en_q   <= 1'b0;
      mode_q     <= '0;
      flag_q     <= 1'b0;
    end else begin
      cmp_hold_q <= cmp_hold_d;
      cmp_act_q  <= cmp_act_d;
      top_q      <= top_d;
      pwm_en_q   <= pwm_en_d;
      mode_q     <= mode_d;
      flag_q     <= flag_d;
    end
  end

  always_comb begin
    ctrl_view = '0;
    ctrl_view[CTRL_PWM_BIT] = pwm_en_q;
    ctrl_view[CTRL_MODE_LSB +: CTRL_MODE_W] = mode_q;
    ctrl_view[FLAG_BIT] = flag_q;
  end

  always_comb begin
    unique case (sel)
      SEL_COUNT: bus_rdata = cnt_q;
      SEL_CMP:   bus_rdata = cmp_act_q;
      SEL_TOP:   bus_rdata = top_q;
      SEL_CTRL:  bus_rdata = ctrl_view;
      default:   bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/pwm_tmr_wave.sv
module pwm_tmr_wave
  import pwm_tmr_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   pwm_en,
  input  logic [CTRL_MODE_W-1:0] mode,
  input  logic                   hit_cmp,
  input  logic                   hit_bottom,
  output logic                   pwm_out,
  output logic                   pwm_oe
);
  timeunit 1ns;
  timeprecision 1ps;

  logic drive;
  logic invert;
  logic wave_q;
  logic wave_d;

  assign drive  = pwm_en & mode[1];
  assign invert = (out_mode_e'(mode) == OUT_SET_ON_MATCH);

  always_comb begin
    wave_d = wave_q;
    if (drive) begin
      if (hit_cmp) begin
        wave_d = invert;
      end else if (hit_bottom) begin
        wave_d = ~invert;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wave_q <= 1'b0;
    end else begin
      wave_q <= wave_d;
    end
  end

  assign pwm_oe  = drive;
  assign pwm_out = drive & wave_q;
endmodule

// File: rtl/pwm_cmp_timer.sv
module pwm_cmp_timer
  import pwm_tmr_pkg::*;
#(
  parameter int           W           = 8,
  parameter logic [W-1:0] TOP_RST     = '1,
  parameter int           SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_en,
  input  logic         bus_we,
  input  logic [1:0]   bus_addr,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  output logic         pwm_out,
  output logic         pwm_oe,
  output logic         cmp_irq
);
  timeunit 1ns;
  timeprecision 1ps;

  logic                   rst_sync_n;
  logic [W-1:0]           cnt_q;
  logic [W-1:0]           top_q;
  logic [W-1:0]           cmp_act_q;
  logic [W-1:0]           ld_val;
  logic                   ld_en;
  logic                   commit;
  logic                   hit_cmp;
  logic                   hit_bottom;
  logic                   pwm_en_q;
  logic [CTRL_MODE_W-1:0] mode_q;

  pwm_tmr_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pwm_tmr_counter #(.W(W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .cnt_en     (cnt_en),
    .pwm_en     (pwm_en_q),
    .top_val    (top_q),
    .ld_en      (ld_en),
    .ld_val     (ld_val),
    .cmp_val    (cmp_act_q),
    .cnt_q      (cnt_q),
    .commit     (commit),
    .hit_cmp    (hit_cmp),
    .hit_bottom (hit_bottom)
  );

  pwm_tmr_regs #(.W(W), .TOP_RST(TOP_RST)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cnt_q     (cnt_q),
    .commit    (commit),
    .hit_cmp   (hit_cmp),
    .ld_en     (ld_en),
    .ld_val    (ld_val),
    .top_q     (top_q),
    .cmp_act_q (cmp_act_q),
    .pwm_en_q  (pwm_en_q),
    .mode_q    (mode_q),
    .flag_q    (cmp_irq)
  );

  pwm_tmr_wave u_wave (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .pwm_en     (pwm_en_q),
    .mode       (mode_q),
    .hit_cmp    (hit_cmp),
    .hit_bottom (hit_bottom),
    .pwm_out    (pwm_out),
    .pwm_oe     (pwm_oe)
  );
endmodule

// File: rtl/pwm_cmp_timer_chk.sv
module pwm_cmp_timer_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cnt_en,
  input logic         bus_we,
  input logic [1:0]   bus_addr,
  input logic [W-1:0] bus_wdata,
  input logic [W-1:0] cnt_q,
  input logic [W-1:0] top_q,
  input logic [W-1:0] cmp_act,
  input logic         pwm_en,
  input logic [1:0]   mode,
  input logic         hit_cmp,
  input logic         cmp_irq,
  input logic         pwm_out,
  input logic         pwm_oe
);
  timeunit 1ns;
  timeprecision 1ps;

  logic cnt_wr;
  logic ctrl_wr;
  assign cnt_wr  = bus_we & (bus_addr == 2'd0);
  assign ctrl_wr = bus_we & (bus_addr == 2'd3);

  AST_FLAG_AFTER_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmp_irq) |-> $past(hit_cmp)); // R4

  AST_FREE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwm_en && cnt_en && !cnt_wr) |=> (cnt_q == W'($past(cnt_q) + 1'b1))); // R2

  AST_PERIOD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_en && cnt_en && !cnt_wr && cnt_q == top_q) |=> (cnt_q == '0)); // R3

  AST_CMP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_en && !(cnt_en && !cnt_wr && cnt_q == top_q)) |=> $stable(cmp_act)); // R8

  AST_CLEAR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && bus_wdata[W-1] && !hit_cmp) |=> !cmp_irq); // R6

  AST_PIN_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !(pwm_en && mode[1]) |-> (!pwm_out && !pwm_oe)); // R9

  AST_NONINV_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_en && mode == 2'b10 && hit_cmp && !ctrl_wr) |=> !pwm_out); // R10

  AST_INV_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_en && mode == 2'b11 && hit_cmp && !ctrl_wr) |=> pwm_out); // R11
endmodule

bind pwm_cmp_timer pwm_cmp_timer_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .cnt_en    (cnt_en),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .cnt_q     (cnt_q),
  .top_q     (top_q),
  .cmp_act   (cmp_act_q),
  .pwm_en    (pwm_en_q),
  .mode      (mode_q),
  .hit_cmp   (hit_cmp),
  .cmp_irq   (cmp_irq),
  .pwm_out   (pwm_out),
  .pwm_oe    (pwm_oe)
);

// File: tb/pwm_cmp_timer_tb_top.sv
module pwm_cmp_timer_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [7:0] TOPV = 8'd4;

  typedef struct {
    int         kind;
    logic [7:0] exp;
    string      req;
  } exp_item_t;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cnt_en;
  logic       bus_we;
  logic [1:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       pwm_out;
  logic       pwm_oe;
  logic       cmp_irq;

  int n_chk = 0;
  int n_fail = 0;
  int pushed = 0;
  int popped = 0;
  bit done = 1'b0;
  exp_item_t sb_q[$];

  logic [7:0] m_cnt, m_act, m_hold;
  logic [1:0] m_mode;
  logic       m_arr, m_out;

  always #2 clk = ~clk;

  pwm_cmp_timer dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_en    (cnt_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pwm_out   (pwm_out),
    .pwm_oe    (pwm_oe),
    .cmp_irq   (cmp_irq)
  );

  // Monitor: pops expected items and compares them with the outputs
  initial begin
    forever begin
      wait (sb_q.size() > 0);
      begin
        exp_item_t it;
        logic [7:0] act;
        it = sb_q.pop_front();
        case (it.kind)
          0:       act = bus_rdata;
          1:       act = {7'd0, pwm_out};
          2:       act = {7'd0, cmp_irq};
          default: act = {7'd0, pwm_oe};
        endcase
        n_chk++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
        end
        popped++;
      end
    end
  end

  task automatic expect_item(input int kind, input logic [1:0] a, input logic [7:0] e, input string req);
    exp_item_t it;
    bus_addr = a;
    #0.1;
    it.kind = kind;
    it.exp  = e;
    it.req  = req;
    sb_q.push_back(it);
    pushed++;
    wait (popped == pushed);
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] e, input string req);
    expect_item(0, a, e, req);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_we = 1'b1;
    bus_addr = a;
    bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  // One counting edge in PWM operation with the reference model advanced
  task automatic pstep(input bit do_wr, input logic [1:0] a, input logic [7:0] d, input string req);
    logic hc, hb;
    cnt_en = 1'b1;
    bus_we = do_wr;
    bus_addr = a;
    bus_wdata = d;
    @(posedge clk);
    hc = m_arr && (m_cnt == m_act);
    hb = m_arr && (m_cnt == 8'd0);
    if (m_mode[1]) m_out = hc ? m_mode[0] : (hb ? ~m_mode[0] : m_out);
    if (m_cnt == TOPV) begin
      m_act = m_hold;
      m_cnt = 8'd0;
    end else begin
      m_cnt = m_cnt + 8'd1;
    end
    m_arr = 1'b1;
    if (do_wr && a == 2'd1) m_hold = d;
    if (do_wr && a == 2'd3) m_mode = d[2:1];
    @(negedge clk);
    bus_we = 1'b0;
    expect_item(1, 2'd0, {7'd0, m_mode[1] & m_out}, req);
    rd(2'd0, m_cnt, "R3");
  endtask

  task automatic prun(input int n, input string req);
    for (int i = 0; i < n; i++) pstep(1'b0, 2'd0, 8'd0, req);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    cnt_en = 1'b0;
    bus_we = 1'b0;
    bus_addr = 2'd0;
    bus_wdata = 8'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(2'd0, 8'h00, "R1");
    rd(2'd1, 8'h00, "R1");
    rd(2'd2, 8'hFF, "R1");
    rd(2'd3, 8'h00, "R1");
    expect_item(2, 2'd0, 8'd0, "R1");
    expect_item(1, 2'd0, 8'd0, "R1");
    expect_item(3, 2'd0, 8'd0, "R1");

    // R2 full-range wrap and write priority
    wr(2'd0, 8'hFD);
    cnt_en = 1'b1;
    repeat (3) @(negedge clk);
    cnt_en = 1'b0;
    rd(2'd0, 8'h00, "R2");
    cnt_en = 1'b1;
    wr(2'd0, 8'h10);
    cnt_en = 1'b0;
    rd(2'd0, 8'h10, "R2");

    // R7 immediate compare write
    wr(2'd1, 8'h05);
    rd(2'd1, 8'h05, "R7");

    // R6 clear (counter passed 0x00 which equalled the reset compare value)
    wr(2'd3, 8'h80);
    expect_item(2, 2'd0, 8'd0, "R6");

    // R4 flag timing
    wr(2'd0, 8'h03);
    cnt_en = 1'b1;
    @(negedge clk);
    expect_item(2, 2'd0, 8'd0, "R4");
    @(negedge clk);
    cnt_en = 1'b0;
    expect_item(2, 2'd0, 8'd0, "R4");
    @(negedge clk);
    expect_item(2, 2'd0, 8'd1, "R4");

    // R6 set wins over clear
    wr(2'd3, 8'h80);
    wr(2'd0, 8'h04);
    cnt_en = 1'b1;
    @(negedge clk);
    cnt_en = 1'b0;
    wr(2'd3, 8'h80);
    expect_item(2, 2'd0, 8'd1, "R6");

    // R5 loaded equality is not a match
    wr(2'd3, 8'h80);
    wr(2'd0, 8'h05);
    repeat (2) @(negedge clk);
    expect_item(2, 2'd0, 8'd0, "R5");

    // PWM setup: limit 4, compare 2, mode 10
    wr(2'd2, TOPV);
    rd(2'd2, TOPV, "R3");
    wr(2'd1, 8'h02);
    wr(2'd0, 8'h00);
    wr(2'd3, 8'h05);
    expect_item(3, 2'd0, 8'd1, "R9");
    m_cnt = 8'd0; m_act = 8'd2; m_hold = 8'd2; m_mode = 2'b10; m_arr = 1'b0; m_out = 1'b0;
    prun(12, "R10");

    // R8 buffered compare write
    if (m_cnt == TOPV) prun(1, "R10");
    pstep(1'b1, 2'd1, 8'h03, "R10");
    rd(2'd1, 8'h02, "R8");
    prun(10, "R10");
    rd(2'd1, 8'h03, "R8");

    // R12 compare zero: steady low
    pstep(1'b1, 2'd1, 8'h00, "R12");
    prun(8, "R12");
    for (int i = 0; i < 5; i++) begin
      pstep(1'b0, 2'd0, 8'd0, "R12");
      expect_item(1, 2'd0, 8'd0, "R12");
    end

    // R12 compare above limit: steady high
    pstep(1'b1, 2'd1, 8'h07, "R12");
    prun(8, "R12");
    for (int i = 0; i < 5; i++) begin
      pstep(1'b0, 2'd0, 8'd0, "R12");
      expect_item(1, 2'd0, 8'd1, "R12");
    end

    // R11 inverted mode
    pstep(1'b1, 2'd3, 8'h07, "R11");
    pstep(1'b1, 2'd1, 8'h02, "R11");
    prun(14, "R11");

    // R9 disconnected mode
    pstep(1'b1, 2'd3, 8'h03, "R9");
    expect_item(3, 2'd0, 8'd0, "R9");
    prun(6, "R9");
    expect_item(1, 2'd0, 8'd0, "R9");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule